// File: doc/BRIEF.md
# Completion Interrupt Pending Controller

This block gathers transfer-complete notifications for 64 DMA channels and turns them into one interrupt request. Each notification carries a 6-bit channel code and a valid strobe. The code sets one bit in a 64-bit pending vector, which is held as two 32-bit banks. The channel number of a pending bit is its bank number shifted left by five, ORed with the bit index inside the bank. A 64-bit enable vector masks the pending vector. Whenever the set of bits that are both enabled and pending goes from empty to non-empty, the block emits a one-cycle interrupt pulse.

Software works through a small register window. It reads the pending and enable words directly. It clears pending bits by writing ones to a clear alias. It sets or clears enable bits through separate set and clear aliases, so a write never disturbs bits it does not name. A handler typically scans from the lowest set pending bit, clears each bit with a one-hot mask, and then writes the evaluate register. If enabled work is still pending at that point, the evaluate write produces a fresh interrupt pulse, so no completion is lost between the scan and the return.

Pending bits are captured whether or not they are enabled, so a channel that is set up later still raises its interrupt. When a completion and a clear hit the same bit in the same cycle, the completion wins.

Top module: `cmpl_irq_ctrl`

## Requirements
- R1: After reset, all pending bits and all enable bits read zero, and `irq_o` is low.
- R2: A cycle with `cmp_valid` high and code c sets pending bit c[4:0] of bank c[5]. Bank 0 reads at 0x68 and bank 1 at 0x6C. The bit is readable on `rd_data` one clock after the strobe is sampled.
- R3: A write to 0x70 (bank 0) or 0x74 (bank 1) clears every pending bit whose data bit is 1. Pending bits written with 0 keep their value.
- R4: If a completion sets a pending bit in the same cycle that a clear write names that bit, the bit ends up set. Other bits named by the same clear are still cleared.
- R5: A write to 0x60/0x64 sets the enable bits written as 1, and a write to 0x58/0x5C clears them. Bits written as 0 are unchanged. The enable banks read at 0x50/0x54.
- R6: Writes to the read-only words 0x50, 0x54, 0x68 and 0x6C change neither the enable bits nor the pending bits.
- R7: A completion on a disabled channel is held as pending and raises no interrupt. Enabling that bit later produces an interrupt pulse.
- R8: `irq_o` is a pulse one cycle long. It is high in the clock that follows the first register update that makes the enabled-pending set non-empty. It stays low while that set is empty.
- R9: A write to 0x78 with data bit 0 set produces a one-cycle pulse on `irq_o` in the following clock, provided the enabled-pending set is non-empty. With that set empty, or with data bit 0 clear, no pulse follows.
- R10: Reads of addresses outside the four pending and enable words, including 0x78, return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_valid | input | 1 | Completion strobe |
| cmp_code | input | 6 | Channel code of the completion |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Byte address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Byte address of the read |
| rd_data | output | 32 | Combinational read data |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
Pending and enable state is due on `rd_data` one clock after the strobe or write is sampled. An interrupt pulse from a newly non-empty set is due one clock after that, and a pulse from an evaluate write is due one clock after the write. The bench drives every input on the falling edge and reads results on the following falling edges, so each sample is taken half a period away from the edge that updates it. The bench checks `irq_o` in the exact cycle the pulse is due and in the cycles on either side of it. It sweeps all 64 channel codes, once with the channels disabled and once with them enabled.

// File: rtl/cmpl_irq_pkg.sv
package cmpl_irq_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned OFS_EN       = 'h50;
    localparam int unsigned OFS_EN_CLR   = 'h58;
    localparam int unsigned OFS_EN_SET   = 'h60;
    localparam int unsigned OFS_PEND     = 'h68;
    localparam int unsigned OFS_PEND_CLR = 'h70;
    localparam int unsigned OFS_EVAL     = 'h78;

    typedef struct packed {
        logic [WORD_W-1:0] pend;
        logic [WORD_W-1:0] en;
    } bank_state_t;

    typedef struct packed {
        logic act_prev;
        logic irq;
    } irq_state_t;
endpackage

// File: rtl/cmpl_code_dec.sv
module cmpl_code_dec #(
    parameter int unsigned NUM_CH = 64,
    localparam int unsigned CODE_W = $clog2(NUM_CH)
) (
    input  logic              valid_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [NUM_CH-1:0] onehot_o
);
    always_comb begin
        onehot_o = '0;
        if (valid_i) begin
            onehot_o[code_i] = 1'b1;
        end
    end
endmodule

// File: rtl/cmpl_bank.sv
module cmpl_bank
    import cmpl_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] set_i,
    input  logic              pend_clr_i,
    input  logic              en_set_i,
    input  logic              en_clr_i,
    input  logic [WORD_W-1:0] wr_data_i,
    output logic [WORD_W-1:0] pend_o,
    output logic [WORD_W-1:0] en_o
);
    bank_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (pend_clr_i) begin
            st_d.pend = st_d.pend & ~wr_data_i;
        end
        st_d.pend = st_d.pend | set_i;
        if (en_set_i) begin
            st_d.en = st_d.en | wr_data_i;
        end
        if (en_clr_i) begin
            st_d.en = st_d.en & ~wr_data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;
    assign en_o   = st_q.en;

    // R2, R4
    set_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((pend_o & $past(set_i)) == $past(set_i)));

    // R3
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_clr_i && ((wr_data_i & ~set_i) != '0))
        |=> ((pend_o & $past(wr_data_i & ~set_i)) == '0));

    // R5
    en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_set_i && !en_clr_i) |=> ((en_o & $past(wr_data_i)) == $past(wr_data_i)));

    // R5
    en_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_clr_i |=> ((en_o & $past(wr_data_i)) == '0));
endmodule

// File: rtl/cmpl_irq_gen.sv
module cmpl_irq_gen
    import cmpl_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic act_i,
    input  logic eval_i,
    output logic irq_o
);
    irq_state_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.act_prev = act_i;
        st_d.irq      = (act_i && !st_q.act_prev) || (eval_i && act_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o = st_q.irq;

    // R8
    irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !act_i |=> !irq_o);

    // R8
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_i && !st_q.act_prev) |=> irq_o);

    // R9
    eval_refire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_i && act_i) |=> irq_o);
endmodule

// File: rtl/cmpl_irq_ctrl.sv
module cmpl_irq_ctrl
    import cmpl_irq_pkg::*;
#(
    parameter int unsigned NUM_CH = 64,
    parameter int unsigned ADDR_W = 8,
    localparam int unsigned CODE_W = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_valid,
    input  logic [CODE_W-1:0] cmp_code,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data,
    output logic              irq_o
);
    localparam int unsigned BANKS = NUM_CH / WORD_W;
    localparam logic [ADDR_W-1:0] A_EVAL = ADDR_W'(OFS_EVAL);

    logic [NUM_CH-1:0] set_vec;
    logic [WORD_W-1:0] pend_w [BANKS];
    logic [WORD_W-1:0] en_w   [BANKS];
    logic [BANKS-1:0]  bank_act;
    logic              act;
    logic              eval_hit;

    cmpl_code_dec #(.NUM_CH(NUM_CH)) u_dec (
        .valid_i  (cmp_valid),
        .code_i   (cmp_code),
        .onehot_o (set_vec)
    );

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        localparam logic [ADDR_W-1:0] A_PCLR = ADDR_W'(OFS_PEND_CLR + 4*b);
        localparam logic [ADDR_W-1:0] A_ESET = ADDR_W'(OFS_EN_SET + 4*b);
        localparam logic [ADDR_W-1:0] A_ECLR = ADDR_W'(OFS_EN_CLR + 4*b);

        cmpl_bank u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .set_i      (set_vec[b*WORD_W +: WORD_W]),
            .pend_clr_i (wr_en && (wr_addr == A_PCLR)),
            .en_set_i   (wr_en && (wr_addr == A_ESET)),
            .en_clr_i   (wr_en && (wr_addr == A_ECLR)),
            .wr_data_i  (wr_data),
            .pend_o     (pend_w[b]),
            .en_o       (en_w[b])
        );

        assign bank_act[b] = |(pend_w[b] & en_w[b]);
    end

    assign act      = |bank_act;
    assign eval_hit = wr_en && (wr_addr == A_EVAL) && wr_data[0];

    always_comb begin
        rd_data = '0;
        for (int b = 0; b < BANKS; b++) begin
            if (rd_addr == ADDR_W'(OFS_EN + 4*b)) begin
                rd_data = en_w[b];
            end
            if (rd_addr == ADDR_W'(OFS_PEND + 4*b)) begin
                rd_data = pend_w[b];
            end
        end
    end

    cmpl_irq_gen u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .act_i  (act),
        .eval_i (eval_hit),
        .irq_o  (irq_o)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !irq_o);
endmodule

// File: tb/cmpl_irq_ctrl_bench.sv
`timescale 1ns/1ps
module cmpl_irq_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmp_valid = 1'b0;
    logic [5:0]  cmp_code = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq_o;
    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    cmpl_irq_ctrl u_cmpl_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_code(cmp_code),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd64(input logic [7:0] base, output logic [63:0] v);
        rd_addr = base;
        #0.2 v[31:0] = rd_data;
        rd_addr = base + 8'd4;
        #0.2 v[63:32] = rd_data;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic complete(input int c);
        cmp_valid = 1'b1; cmp_code = 6'(c);
        @(negedge clk);
        cmp_valid = 1'b0;
    endtask

    task automatic clear_ch(input int c);
        wr((c < 32) ? 8'h70 : 8'h74, 32'(1) << (c % 32));
    endtask

    initial begin
        logic [63:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd64(8'h68, v); chk("R1 pend", v, 64'h0);
        rd64(8'h50, v); chk("R1 en", v, 64'h0);
        chk("R1 irq", 64'(irq_o), 64'h0);

        // R2 R3 R7 sweep with all channels disabled
        for (int c = 0; c < 64; c++) begin
            complete(c);
            rd64(8'h68, v); chk("R2 set", v, 64'(1) << c);
            @(negedge clk);
            chk("R7 no irq while disabled", 64'(irq_o), 64'h0);
            clear_ch(c);
            rd64(8'h68, v); chk("R3 clear", v, 64'h0);
        end

        // R3 zero bits keep value
        complete(9); complete(50);
        wr(8'h70, 32'h0000_0100);
        rd64(8'h68, v); chk("R3 partial clear", v, (64'(1) << 50) | (64'(1) << 9));
        wr(8'h74, 32'h0004_0000); wr(8'h70, 32'h0000_0200);
        rd64(8'h68, v); chk("R3 clear both", v, 64'h0);

        // R4 set wins over same-cycle clear
        complete(5); complete(6);
        cmp_valid = 1'b1; cmp_code = 6'd5;
        wr(8'h70, 32'h0000_0060);
        cmp_valid = 1'b0;
        rd64(8'h68, v); chk("R4 set wins", v, 64'h20);
        wr(8'h70, 32'h20);

        // R5 enable aliases
        wr(8'h60, 32'hffff_ffff); wr(8'h64, 32'hffff_ffff);
        rd64(8'h50, v); chk("R5 set all", v, 64'hffff_ffff_ffff_ffff);
        wr(8'h58, 32'h0);
        rd64(8'h50, v); chk("R5 zero clear no effect", v, 64'hffff_ffff_ffff_ffff);
        wr(8'h5C, 32'h8000_0001);
        rd64(8'h50, v); chk("R5 clear alias", v, 64'h7fff_fffe_ffff_ffff);
        wr(8'h64, 32'h8000_0001);
        rd64(8'h50, v); chk("R5 set alias", v, 64'hffff_ffff_ffff_ffff);

        // R6 read-only words
        wr(8'h58, 32'h0000_00ff);
        wr(8'h50, 32'hffff_ffff); wr(8'h54, 32'h0);
        rd64(8'h50, v); chk("R6 en ro", v, 64'hffff_ffff_ffff_ff00);
        wr(8'h68, 32'hffff_ffff); wr(8'h6C, 32'hffff_ffff);
        rd64(8'h68, v); chk("R6 pend ro", v, 64'h0);
        wr(8'h60, 32'h0000_00ff);

        // R8 enabled sweep, pulse timing
        for (int c = 0; c < 64; c++) begin
            complete(c);
            chk("R8 irq before due", 64'(irq_o), 64'h0);
            @(negedge clk);
            chk("R8 irq pulse", 64'(irq_o), 64'h1);
            @(negedge clk);
            chk("R8 irq one cycle", 64'(irq_o), 64'h0);
            clear_ch(c);
            @(negedge clk);
            chk("R8 irq quiet after clear", 64'(irq_o), 64'h0);
        end

        // R9 evaluate write
        complete(3);
        repeat (3) @(negedge clk);
        chk("R9 settled", 64'(irq_o), 64'h0);
        wr(8'h78, 32'h1);
        chk("R9 refire", 64'(irq_o), 64'h1);
        @(negedge clk);
        chk("R9 refire one cycle", 64'(irq_o), 64'h0);
        wr(8'h78, 32'h2);
        chk("R9 bit0 clear no pulse", 64'(irq_o), 64'h0);
        clear_ch(3);
        @(negedge clk);
        wr(8'h78, 32'h1);
        chk("R9 empty no pulse", 64'(irq_o), 64'h0);
        @(negedge clk);
        chk("R9 empty stays low", 64'(irq_o), 64'h0);

        // R7 enable later
        wr(8'h58, 32'hffff_ffff); wr(8'h5C, 32'hffff_ffff);
        complete(40);
        repeat (2) @(negedge clk);
        chk("R7 held no irq", 64'(irq_o), 64'h0);
        rd64(8'h68, v); chk("R7 held pend", v, 64'(1) << 40);
        wr(8'h64, 32'h0000_0100);
        chk("R7 not yet", 64'(irq_o), 64'h0);
        @(negedge clk);
        chk("R7 enable fires", 64'(irq_o), 64'h1);

        // R10 unmapped reads
        rd_addr = 8'h78; #0.2 chk("R10 eval reads 0", 64'(rd_data), 64'h0);
        rd_addr = 8'h7C; #0.2 chk("R10 unmapped 7C", 64'(rd_data), 64'h0);
        rd_addr = 8'h00; #0.2 chk("R10 unmapped 00", 64'(rd_data), 64'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule